// File: doc/BRIEF.md
# Outstanding Atomic Operation Tracker

This block sits beside a shared cache and follows, line by line, the atomic operations that the cache has sent on to memory and that memory has not yet answered. Before the first atomic to a line goes out, the block drops the local copy of that line. It opens a tracking entry for the line and counts each atomic sent. As memory answers, it hands each result to the requester that issued that atomic, in issue order.

When the last answer for a line arrives, the block does not free the entry at once. It posts a completion trigger to itself, and that trigger is handled two cycles after the answer. If no atomic to the line arrived in the meantime, the entry is released and the line returns to invalid. If one did arrive, the trigger is dropped and the line keeps waiting. An atomic to a dirty line is held back: the block asks for a writeback, keeps the line in a waiting-on-writeback entry, and stalls the requester until memory acknowledges the writeback. The arithmetic of the atomics is done elsewhere.

Top module: `atomic_tracker`

## Requirements
- R1: An atomic (`iss_valid`) to an untracked line whose state code `iss_line` is clean (2'b00 invalid, 2'b01 valid) is accepted in the same cycle (`iss_ready` high) when an entry is free. In the next cycle `fwd_valid` pulses with the address and requester ID, and `inv_valid` pulses with the same address.
- R2: An atomic to a line that already has a waiting-on-atomic entry is accepted without stall and forwarded. No `inv_valid` pulse is given for it.
- R3: An atomic to an untracked line whose state code is dirty (`iss_line[1]` = 1: 2'b10 modified, 2'b11 written) is not accepted, and nothing is forwarded. A single `wb_valid` pulse with the address follows in the next cycle. Later atomics to that line stall, with no further writeback request, until `wba_valid` for the address releases the entry.
- R4: A memory answer (`mem_valid`) for a line waiting on atomics appears one cycle later on `rsp_valid`, with `mem_data` and the requester IDs in the order their atomics were forwarded.
- R5: When an answer brings a line's count to zero, `done_valid` pulses with the address in the second cycle after the `rsp_valid` cycle of that answer, and not before.
- R6: If an atomic to the line was accepted between that answer and the handling of its trigger, the trigger is discarded: no `done_valid` pulse, and the line goes on waiting for its answers.
- R7: With `2**CNT_W-1` atomics outstanding on a line, a further atomic to that line stalls and is not forwarded. It is accepted again once an answer has come back.
- R8: In the cycle in which a completion trigger is handled, no atomic is accepted, whatever its address.
- R9: A memory answer whose address has no waiting-on-atomic entry produces no `rsp_valid`.
- R10: When all `N_ENT` entries are in use, an atomic to a further line stalls until an entry is released.
- R11: Out of reset, every valid output and `iss_ready` is low.
- R12: After `done_valid`, an atomic to the same address is treated as a first atomic again, with a new `inv_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Atomic request present |
| iss_addr | input | ADDR_W | Line address of the atomic |
| iss_id | input | ID_W | Requester ID |
| iss_line | input | 2 | Present cache state of the line (00 I, 01 V, 10 M, 11 W) |
| iss_ready | output | 1 | Atomic accepted this cycle |
| mem_valid | input | 1 | Atomic answer from memory |
| mem_addr | input | ADDR_W | Line address of the answer |
| mem_data | input | DATA_W | Answer data |
| wba_valid | input | 1 | Writeback acknowledge from memory |
| wba_addr | input | ADDR_W | Line address of the acknowledge |
| fwd_valid | output | 1 | Atomic forwarded to memory |
| fwd_addr | output | ADDR_W | Address of the forwarded atomic |
| fwd_id | output | ID_W | Requester of the forwarded atomic |
| inv_valid | output | 1 | Drop the local copy of the line |
| inv_addr | output | ADDR_W | Line to drop |
| wb_valid | output | 1 | Writeback request for a dirty line |
| wb_addr | output | ADDR_W | Line to write back |
| rsp_valid | output | 1 | Atomic result to a requester |
| rsp_id | output | ID_W | Requester receiving the result |
| rsp_data | output | DATA_W | Result data |
| done_valid | output | 1 | Line released back to invalid |
| done_addr | output | ADDR_W | Released line |

## Verification
The bench goes after the race between the self-posted trigger and a late atomic to the same line. A design that freed the entry straight from the answer, or that ignored the count when the trigger arrives, would pulse `done_valid` while an atomic was still outstanding and then lose that atomic's answer. It checks that the stall caused by trigger priority lasts exactly one cycle, and that the count stops at its ceiling. A design that wrapped the count would forward a fourth atomic and then release the line early. The dirty-line path is checked for a single writeback and no forwarding. Answers to untracked lines and a full entry table are checked too: a loose address match would send stray results to requesters.

// File: rtl/atq_pkg.sv
package atq_pkg;
    // cache line state codes presented with an atomic
    typedef enum logic [1:0] {
        LS_INV   = 2'b00,
        LS_CLEAN = 2'b01,
        LS_MOD   = 2'b10,
        LS_WRIT  = 2'b11
    } line_st_e;

    function automatic logic is_dirty(input logic [1:0] code);
        return code[1];
    endfunction
endpackage

// File: rtl/atq_match.sv
module atq_match #(
    parameter int N  = 4,
    parameter int AW = 16,
    parameter int IW = 2
) (
    input  logic [N-1:0]         vld,
    input  logic [N-1:0][AW-1:0] tags,
    input  logic [AW-1:0]        key,
    output logic [N-1:0]         hit,
    output logic                 any,
    output logic [IW-1:0]        idx
);
    always_comb begin
        hit = '0;
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            hit[i] = vld[i] && (tags[i] == key);
        end
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/atq_pick.sv
module atq_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  free,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/atq_trig.sv
module atq_trig #(
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          post_v,
    input  logic [IW-1:0] post_idx,
    output logic          fire_v,
    output logic [IW-1:0] fire_idx
);
    typedef struct packed {
        logic          s1_v;
        logic [IW-1:0] s1_idx;
        logic          s2_v;
        logic [IW-1:0] s2_idx;
    } trig_t;

    trig_t trg_d, trg_q;

    always_comb begin
        trg_d        = trg_q;
        trg_d.s1_v   = post_v;
        trg_d.s1_idx = post_idx;
        trg_d.s2_v   = trg_q.s1_v;
        trg_d.s2_idx = trg_q.s1_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trg_q <= '0;
        else        trg_q <= trg_d;
    end

    assign fire_v   = trg_q.s2_v;
    assign fire_idx = trg_q.s2_idx;

    // R5
    trig_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post_v |=> ##1 fire_v);
endmodule

// File: rtl/atomic_tracker.sv
module atomic_tracker #(
    parameter int ADDR_W = 16,
    parameter int ID_W   = 4,
    parameter int DATA_W = 32,
    parameter int N_ENT  = 4,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [ADDR_W-1:0] iss_addr,
    input  logic [ID_W-1:0]   iss_id,
    input  logic [1:0]        iss_line,
    output logic              iss_ready,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_data,
    input  logic              wba_valid,
    input  logic [ADDR_W-1:0] wba_addr,
    output logic              fwd_valid,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [ID_W-1:0]   fwd_id,
    output logic              inv_valid,
    output logic [ADDR_W-1:0] inv_addr,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic              rsp_valid,
    output logic [ID_W-1:0]   rsp_id,
    output logic [DATA_W-1:0] rsp_data,
    output logic              done_valid,
    output logic [ADDR_W-1:0] done_addr
);
    import atq_pkg::*;

    localparam int IW    = (N_ENT > 1) ? $clog2(N_ENT) : 1;
    localparam int DEPTH = 2 ** CNT_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic              vld;
        logic              wbw;   // 1: waiting on writeback, 0: waiting on atomics
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  rp;
        logic [CNT_W-1:0]  wp;
    } ent_t;

    typedef struct packed {
        ent_t [N_ENT-1:0]                       ent;
        logic [N_ENT-1:0][DEPTH-1:0][ID_W-1:0]  ids;
        logic                                   fwd_v;
        logic                                   inv_v;
        logic                                   wb_v;
        logic [ADDR_W-1:0]                      o_addr;
        logic [ID_W-1:0]                        o_id;
        logic                                   rsp_v;
        logic [ID_W-1:0]                        rsp_id;
        logic [DATA_W-1:0]                      rsp_data;
        logic                                   done_v;
        logic [ADDR_W-1:0]                      done_addr;
    } st_t;

    st_t st_d, st_q;

    logic [N_ENT-1:0]             ent_vld;
    logic [N_ENT-1:0]             ent_free;
    logic [N_ENT-1:0][ADDR_W-1:0] ent_tag;
    logic [N_ENT-1:0]             iss_hit, mem_hit, wba_hit;
    logic                         iss_any, mem_any, wba_any, free_any;
    logic [IW-1:0]                iss_idx, mem_idx, wba_idx, free_idx;
    logic [N_ENT-1:0]             inc, dec;
    logic                         post_v;
    logic [IW-1:0]                post_idx;
    logic                         fire_v;
    logic [IW-1:0]                fire_idx;
    logic                         accept;

    always_comb begin
        for (int i = 0; i < N_ENT; i++) begin
            ent_vld[i]  = st_q.ent[i].vld;
            ent_free[i] = !st_q.ent[i].vld;
            ent_tag[i]  = st_q.ent[i].addr;
        end
    end

    atq_match #(.N(N_ENT), .AW(ADDR_W), .IW(IW)) u_iss_match (
        .vld(ent_vld), .tags(ent_tag), .key(iss_addr),
        .hit(iss_hit), .any(iss_any), .idx(iss_idx));

    atq_match #(.N(N_ENT), .AW(ADDR_W), .IW(IW)) u_mem_match (
        .vld(ent_vld), .tags(ent_tag), .key(mem_addr),
        .hit(mem_hit), .any(mem_any), .idx(mem_idx));

    atq_match #(.N(N_ENT), .AW(ADDR_W), .IW(IW)) u_wba_match (
        .vld(ent_vld), .tags(ent_tag), .key(wba_addr),
        .hit(wba_hit), .any(wba_any), .idx(wba_idx));

    atq_pick #(.N(N_ENT), .IW(IW)) u_pick (
        .free(ent_free), .any(free_any), .idx(free_idx));

    atq_trig #(.IW(IW)) u_trig (
        .clk(clk), .rst_n(rst_n),
        .post_v(post_v), .post_idx(post_idx),
        .fire_v(fire_v), .fire_idx(fire_idx));

    always_comb begin
        st_d          = st_q;
        st_d.fwd_v    = 1'b0;
        st_d.inv_v    = 1'b0;
        st_d.wb_v     = 1'b0;
        st_d.rsp_v    = 1'b0;
        st_d.done_v   = 1'b0;
        accept        = 1'b0;
        inc           = '0;
        dec           = '0;
        post_v        = 1'b0;
        post_idx      = '0;

        // atomic issue; a pending trigger wins the cycle
        if (iss_valid && !fire_v) begin
            if (iss_any) begin
                if (!st_q.ent[iss_idx].wbw && st_q.ent[iss_idx].cnt != CNT_MAX) begin
                    accept       = 1'b1;
                    inc[iss_idx] = 1'b1;
                end
            end else if (free_any) begin
                st_d.ent[free_idx].vld  = 1'b1;
                st_d.ent[free_idx].addr = iss_addr;
                st_d.ent[free_idx].cnt  = '0;
                st_d.ent[free_idx].rp   = '0;
                st_d.ent[free_idx].wp   = '0;
                st_d.o_addr             = iss_addr;
                if (is_dirty(iss_line)) begin
                    st_d.ent[free_idx].wbw = 1'b1;
                    st_d.wb_v              = 1'b1;
                end else begin
                    st_d.ent[free_idx].wbw = 1'b0;
                    st_d.inv_v             = 1'b1;
                    accept                 = 1'b1;
                    inc[free_idx]          = 1'b1;
                end
            end
        end

        if (accept) begin
            st_d.fwd_v  = 1'b1;
            st_d.o_addr = iss_addr;
            st_d.o_id   = iss_id;
        end

        // memory answer to a line waiting on atomics
        if (mem_valid && mem_any && !st_q.ent[mem_idx].wbw && st_q.ent[mem_idx].cnt != '0) begin
            dec[mem_idx]  = 1'b1;
            st_d.rsp_v    = 1'b1;
            st_d.rsp_id   = st_q.ids[mem_idx][st_q.ent[mem_idx].rp];
            st_d.rsp_data = mem_data;
        end

        // writeback acknowledge releases a waiting-on-writeback entry
        if (wba_valid && wba_any && st_q.ent[wba_idx].wbw) begin
            st_d.ent[wba_idx].vld = 1'b0;
            st_d.ent[wba_idx].wbw = 1'b0;
        end

        // completion trigger: release only when nothing is outstanding
        if (fire_v && st_q.ent[fire_idx].vld && !st_q.ent[fire_idx].wbw
                && st_q.ent[fire_idx].cnt == '0) begin
            st_d.ent[fire_idx].vld = 1'b0;
            st_d.done_v            = 1'b1;
            st_d.done_addr         = st_q.ent[fire_idx].addr;
        end

        for (int i = 0; i < N_ENT; i++) begin
            if (inc[i]) begin
                st_d.ids[i][st_d.ent[i].wp] = iss_id;
                st_d.ent[i].wp              = st_d.ent[i].wp + 1'b1;
            end
            if (dec[i]) begin
                st_d.ent[i].rp = st_d.ent[i].rp + 1'b1;
            end
            st_d.ent[i].cnt = st_d.ent[i].cnt + CNT_W'(inc[i]) - CNT_W'(dec[i]);
        end

        if (mem_any && dec[mem_idx] && st_d.ent[mem_idx].cnt == '0) begin
            post_v   = 1'b1;
            post_idx = mem_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign iss_ready  = accept;
    assign fwd_valid  = st_q.fwd_v;
    assign fwd_addr   = st_q.o_addr;
    assign fwd_id     = st_q.o_id;
    assign inv_valid  = st_q.inv_v;
    assign inv_addr   = st_q.o_addr;
    assign wb_valid   = st_q.wb_v;
    assign wb_addr    = st_q.o_addr;
    assign rsp_valid  = st_q.rsp_v;
    assign rsp_id     = st_q.rsp_id;
    assign rsp_data   = st_q.rsp_data;
    assign done_valid = st_q.done_v;
    assign done_addr  = st_q.done_addr;

    // R1
    fwd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_ready |=> fwd_valid);

    // R3
    wb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !fwd_valid && $past(iss_valid) && $past(iss_line[1]));

    // R4
    rsp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(mem_valid));

    // R8
    trig_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_v |-> !iss_ready);

    // R10
    uniq_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(iss_hit) && $onehot0(mem_hit) && $onehot0(wba_hit));

    // R9
    rsp_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_any) |=> !rsp_valid);

    generate
        for (genvar g = 0; g < N_ENT; g++) begin : g_ent_chk
            // R7
            no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.ent[g].vld && st_q.ent[g].cnt == CNT_MAX) |=> st_q.ent[g].cnt != '0);
        end
    endgenerate
endmodule

// File: tb/sim_atomic_tracker.sv
`timescale 1ns/1ps
module sim_atomic_tracker;
    localparam int AW = 16, IDW = 4, DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic [AW-1:0] iss_addr = '0;
    logic [IDW-1:0] iss_id = '0;
    logic [1:0]    iss_line = 2'b00;
    logic          iss_ready;
    logic          mem_valid = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic [DW-1:0] mem_data = '0;
    logic          wba_valid = 1'b0;
    logic [AW-1:0] wba_addr = '0;
    logic          fwd_valid, inv_valid, wb_valid, rsp_valid, done_valid;
    logic [AW-1:0] fwd_addr, inv_addr, wb_addr, done_addr;
    logic [IDW-1:0] fwd_id, rsp_id;
    logic [DW-1:0] rsp_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    atomic_tracker u0 (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_addr(iss_addr), .iss_id(iss_id),
        .iss_line(iss_line), .iss_ready(iss_ready),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
        .wba_valid(wba_valid), .wba_addr(wba_addr),
        .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_id(fwd_id),
        .inv_valid(inv_valid), .inv_addr(inv_addr),
        .wb_valid(wb_valid), .wb_addr(wb_addr),
        .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data),
        .done_valid(done_valid), .done_addr(done_addr));

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        iss_valid = 1'b0;
        mem_valid = 1'b0;
        wba_valid = 1'b0;
    endtask

    // drive an atomic, return acceptance, then cross one edge
    task automatic issue(input logic [AW-1:0] a, input logic [IDW-1:0] id,
                         input logic [1:0] ls, output logic rdy);
        iss_valid = 1'b1; iss_addr = a; iss_id = id; iss_line = ls;
        #1 rdy = iss_ready;
        tick();
        iss_valid = 1'b0;
    endtask

    task automatic answer(input logic [AW-1:0] a, input logic [DW-1:0] dat);
        mem_valid = 1'b1; mem_addr = a; mem_data = dat;
        tick();
        mem_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R11 fwd_valid", fwd_valid, 0);
        check("R11 inv/wb/rsp/done", {inv_valid, wb_valid, rsp_valid, done_valid}, 0);
        check("R11 iss_ready", iss_ready, 0);
    endtask

    task automatic t_basic();
        logic r;
        issue(16'h0100, 4'd3, 2'b00, r);
        check("R1 ready", r, 1);
        check("R1 fwd", {fwd_valid, fwd_addr, fwd_id}, {1'b1, 16'h0100, 4'd3});
        check("R1 inv", {inv_valid, inv_addr}, {1'b1, 16'h0100});
        issue(16'h0100, 4'd5, 2'b00, r);
        check("R2 ready", r, 1);
        check("R2 fwd", {fwd_valid, fwd_id}, {1'b1, 4'd5});
        check("R2 no inv", inv_valid, 0);
        answer(16'h0100, 32'hAAAA0001);
        check("R4 first rsp", {rsp_valid, rsp_id, rsp_data}, {1'b1, 4'd3, 32'hAAAA0001});
        check("R5 no early done", done_valid, 0);
        answer(16'h0100, 32'hBBBB0002);
        check("R4 second rsp", {rsp_valid, rsp_id, rsp_data}, {1'b1, 4'd5, 32'hBBBB0002});
        tick();
        check("R5 done not yet", done_valid, 0);
        tick();
        check("R5 done", {done_valid, done_addr}, {1'b1, 16'h0100});
        tick();
        check("R5 done single pulse", done_valid, 0);
        issue(16'h0100, 4'd7, 2'b01, r);
        check("R12 reuse inv", {r, inv_valid, inv_addr}, {1'b1, 1'b1, 16'h0100});
        answer(16'h0100, 32'h1);
        tick(); tick();
        check("R12 done again", done_valid, 1);
        tick();
    endtask

    task automatic t_discard();
        logic r;
        issue(16'h0200, 4'd1, 2'b00, r);
        answer(16'h0200, 32'h11);
        check("R4 rsp id1", {rsp_valid, rsp_id}, {1'b1, 4'd1});
        issue(16'h0200, 4'd2, 2'b00, r);
        check("R6 late atomic accepted", r, 1);
        check("R6 late atomic no inv", {fwd_valid, inv_valid}, 2'b10);
        issue(16'h0200, 4'd4, 2'b00, r);
        check("R8 stall under trigger", r, 0);
        check("R6 trigger discarded", done_valid, 0);
        check("R8 nothing forwarded", fwd_valid, 0);
        answer(16'h0200, 32'h22);
        check("R6 line still waiting", {rsp_valid, rsp_id, rsp_data}, {1'b1, 4'd2, 32'h22});
        tick(); tick();
        check("R6 done after last answer", {done_valid, done_addr}, {1'b1, 16'h0200});
        tick();
    endtask

    task automatic t_sat();
        logic r;
        for (int k = 1; k <= 3; k++) begin
            issue(16'h0300, 4'(k), 2'b00, r);
            check("R7 below ceiling accepted", r, 1);
        end
        issue(16'h0300, 4'd9, 2'b00, r);
        check("R7 stall at ceiling", r, 0);
        check("R7 not forwarded", fwd_valid, 0);
        answer(16'h0300, 32'h31);
        check("R7 rsp id1", rsp_id, 4'd1);
        issue(16'h0300, 4'd9, 2'b00, r);
        check("R7 accepted after answer", {r, fwd_valid}, 2'b11);
        answer(16'h0300, 32'h32);
        check("R4 order id2", rsp_id, 4'd2);
        answer(16'h0300, 32'h33);
        check("R4 order id3", rsp_id, 4'd3);
        answer(16'h0300, 32'h34);
        check("R4 order id9", rsp_id, 4'd9);
        tick(); tick();
        check("R5 sat done", done_valid, 1);
        tick();
    endtask

    task automatic t_dirty();
        logic r;
        issue(16'h0400, 4'd6, 2'b10, r);
        check("R3 not accepted", r, 0);
        check("R3 writeback", {wb_valid, wb_addr, fwd_valid, inv_valid}, {1'b1, 16'h0400, 2'b00});
        issue(16'h0400, 4'd6, 2'b11, r);
        check("R3 still stalled", r, 0);
        check("R3 one writeback", {wb_valid, fwd_valid}, 2'b00);
        wba_valid = 1'b1; wba_addr = 16'h0400;
        tick();
        wba_valid = 1'b0;
        issue(16'h0400, 4'd6, 2'b00, r);
        check("R3 accepted after ack", {r, fwd_valid, inv_valid}, 3'b111);
        answer(16'h0400, 32'h4);
        tick(); tick();
        check("R3 done", done_valid, 1);
        tick();
    endtask

    task automatic t_stray();
        answer(16'h0777, 32'hDEAD);
        check("R9 stray ignored", rsp_valid, 0);
    endtask

    task automatic t_full();
        logic r;
        for (int k = 0; k < 4; k++) begin
            issue(16'h0500 + 16'(k), 4'(k), 2'b00, r);
            check("R10 fill", r, 1);
        end
        issue(16'h0504, 4'd8, 2'b00, r);
        check("R10 full stall", {r, fwd_valid}, 2'b00);
        for (int k = 0; k < 4; k++) begin
            answer(16'h0500 + 16'(k), 32'(k));
            check("R4 drain id", rsp_id, 4'(k));
        end
        tick(); tick(); tick();
        issue(16'h0504, 4'd8, 2'b00, r);
        check("R10 accepted after release", {r, inv_valid}, 2'b11);
        answer(16'h0504, 32'h5);
        tick(); tick(); tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        tick();
        t_basic();
        t_discard();
        t_sat();
        t_dirty();
        t_stray();
        t_full();
        idle();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule